// File: doc/BRIEF.md
# Windowed Graphics Memory Address Generator

This block holds a one-bit-per-pixel display memory of 40 rows by 16 bytes and walks it for a host through a programmable rectangular box. Each byte covers eight horizontally adjacent pixels, with bit 7 holding the leftmost pixel of the group. Bytes are placed at linear address `y*16 + x`, where x is the byte column (0 to 15) and y is the row (0 to 39). The host loads a box (start and end byte column, start and end row) and a walk-mode code. It then streams data bytes in or out, and the current address steps through the box after every byte.

Reads are pipelined through a holding latch. The first read strobe after any box load, mode load, write or reset is a dummy read that only fetches. Each later read strobe returns the byte fetched by the previous strobe. A soft reset input restores the default box and mode. The memory contents are left untouched.

Top module: `gram_window_addr`

## Requirements
- R1: After hard reset, `ram_addr` is 0, `ram_we` is 0 and `rd_valid` is 0. The box is the whole memory (x 0..15, y 0..39) and the walk mode is 00h.
- R2: In a cycle with `wr_valid` high and no load or soft reset, `ram_we` is high in the same cycle and `wr_data` is stored at `ram_addr`. `ram_addr` always stays below 640.
- R3: With walk mode 00h, addresses run x from the box start column to the end column, then x reloads to the start column and y advances by one.
- R4: After the last cell of the box, the next step returns the address to the box's starting corner.
- R5: Mode bit 0 set walks x downward, starting from the end column. Mode bit 1 set walks y downward, starting from the end row.
- R6: Mode bit 3 set walks y first (column-first): y runs through the box, then reloads while x steps. Mode bits 2 and 7..4 have no effect.
- R7: A box load or mode load sets the address to the starting corner of the new settings on the next cycle. In that cycle, write and read strobes are ignored: `ram_we` stays low and no read is returned.
- R8: Box coordinates above 15 (x) or 39 (y) are clamped to 15 or 39. An end value below its start is raised to the start.
- R9: The first read strobe after a load, a write or a reset gives `rd_valid` low. Each later strobe gives `rd_valid` high one cycle later, with bytes in walk order beginning at the starting corner.
- R10: `soft_rst` returns the box and mode to their defaults and the address to 0. It does not alter memory contents.
- R11: When `wr_valid` and `rd_req` are both high, only the write takes place. No read data is returned and the address advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous settings reset; memory kept |
| box_we | input | 1 | Load the box coordinates |
| box_xs | input | 8 | Box start byte column |
| box_ys | input | 8 | Box start row |
| box_xe | input | 8 | Box end byte column |
| box_ye | input | 8 | Box end row |
| dir_we | input | 1 | Load the walk-mode code |
| dir_code | input | 8 | Walk mode: bit0 x down, bit1 y down, bit3 column-first |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_req | input | 1 | Host read strobe |
| rd_valid | output | 1 | Read byte valid (one cycle after strobe) |
| rd_data | output | 8 | Read byte |
| ram_addr | output | 10 | Current memory address |
| ram_we | output | 1 | Memory write enable |
| ram_rdata | output | 8 | Memory byte at current address |

## Verification
The bench builds the block with its default parameters: 16 byte columns, 40 rows and 8-bit coordinates. These values make the coordinate ports wider than the axes. Out-of-range values such as 80h and FFh can then reach the clamp, and the 640-entry memory can be filled and walked through its full-memory wrap. The power-of-two column count selects the concatenated address variant. Small boxes placed away from the memory edges expose the reload and corner behaviour in all four up/down combinations and in column-first order.

// File: rtl/gwa_pkg.sv
package gwa_pkg;
   localparam int MODE_XDOWN_BIT = 0;
   localparam int MODE_YDOWN_BIT = 1;
   localparam int MODE_COLF_BIT  = 3;

   typedef struct packed {
      logic colf;
      logic ydown;
      logic xdown;
   } walk_mode_t;

   function automatic walk_mode_t decode_mode(input logic [7:0] code);
      walk_mode_t m;
      m.colf  = code[MODE_COLF_BIT];
      m.ydown = code[MODE_YDOWN_BIT];
      m.xdown = code[MODE_XDOWN_BIT];
      return m;
   endfunction
endpackage

// File: rtl/gwa_box_regs.sv
module gwa_box_regs
   import gwa_pkg::*;
#(
   parameter int COLS = 16,
   parameter int ROWS = 40,
   parameter int CW   = 8,
   parameter int XW   = 4,
   parameter int YW   = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          box_we,
   input  logic [CW-1:0] xs_i,
   input  logic [CW-1:0] ys_i,
   input  logic [CW-1:0] xe_i,
   input  logic [CW-1:0] ye_i,
   input  logic          dir_we,
   input  logic [7:0]    dir_i,
   output logic [XW-1:0] xs_n,
   output logic [XW-1:0] xe_n,
   output logic [YW-1:0] ys_n,
   output logic [YW-1:0] ye_n,
   output walk_mode_t    mode_n
);
   localparam logic [XW-1:0] XMAX = XW'(COLS-1);
   localparam logic [YW-1:0] YMAX = YW'(ROWS-1);

   logic [XW-1:0] xs_q, xe_q;
   logic [YW-1:0] ys_q, ye_q;
   walk_mode_t    mode_q;

   function automatic logic [XW-1:0] clamp_x(input logic [CW-1:0] v);
      if (v > CW'(COLS-1)) return XMAX;
      return v[XW-1:0];
   endfunction

   function automatic logic [YW-1:0] clamp_y(input logic [CW-1:0] v);
      if (v > CW'(ROWS-1)) return YMAX;
      return v[YW-1:0];
   endfunction

   always_comb begin
      xs_n   = xs_q;
      xe_n   = xe_q;
      ys_n   = ys_q;
      ye_n   = ye_q;
      mode_n = mode_q;
      if (soft_rst) begin
         xs_n   = '0;
         xe_n   = XMAX;
         ys_n   = '0;
         ye_n   = YMAX;
         mode_n = '0;
      end else begin
         if (box_we) begin
            xs_n = clamp_x(xs_i);
            xe_n = clamp_x(xe_i);
            ys_n = clamp_y(ys_i);
            ye_n = clamp_y(ye_i);
            if (xe_n < xs_n) xe_n = xs_n;
            if (ye_n < ys_n) ye_n = ys_n;
         end
         if (dir_we) mode_n = decode_mode(dir_i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xs_q   <= '0;
         xe_q   <= XMAX;
         ys_q   <= '0;
         ye_q   <= YMAX;
         mode_q <= '0;
      end else begin
         xs_q   <= xs_n;
         xe_q   <= xe_n;
         ys_q   <= ys_n;
         ye_q   <= ye_n;
         mode_q <= mode_n;
      end
   end
endmodule

// File: rtl/gwa_walker.sv
module gwa_walker
   import gwa_pkg::*;
#(
   parameter int XW = 4,
   parameter int YW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [XW-1:0] xs,
   input  logic [XW-1:0] xe,
   input  logic [YW-1:0] ys,
   input  logic [YW-1:0] ye,
   input  walk_mode_t    mode,
   output logic [XW-1:0] x_o,
   output logic [YW-1:0] y_o
);
   logic [XW-1:0] x_q, x_first, x_last, x_adv;
   logic [YW-1:0] y_q, y_first, y_last, y_adv;

   assign x_first = mode.xdown ? xe : xs;
   assign x_last  = mode.xdown ? xs : xe;
   assign y_first = mode.ydown ? ye : ys;
   assign y_last  = mode.ydown ? ys : ye;
   assign x_adv   = mode.xdown ? x_q - 1'b1 : x_q + 1'b1;
   assign y_adv   = mode.ydown ? y_q - 1'b1 : y_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
      end else if (load) begin
         x_q <= x_first;
         y_q <= y_first;
      end else if (step) begin
         if (!mode.colf) begin
            if (x_q == x_last) begin
               x_q <= x_first;
               y_q <= (y_q == y_last) ? y_first : y_adv;
            end else begin
               x_q <= x_adv;
            end
         end else begin
            if (y_q == y_last) begin
               y_q <= y_first;
               x_q <= (x_q == x_last) ? x_first : x_adv;
            end else begin
               y_q <= y_adv;
            end
         end
      end
   end

   assign x_o = x_q;
   assign y_o = y_q;
endmodule

// File: rtl/gwa_ram.sv
module gwa_ram #(
   parameter int COLS = 16,
   parameter int ROWS = 40,
   parameter int DW   = 8,
   parameter int XW   = 4,
   parameter int YW   = 6,
   parameter int AW   = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [XW-1:0] x,
   input  logic [YW-1:0] y,
   input  logic [DW-1:0] wdata,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] rdata_o
);
   localparam int DEPTH = COLS * ROWS;

   logic [DW-1:0] mem [DEPTH];

   generate
      if ((COLS & (COLS - 1)) == 0 && (XW + YW) == AW) begin : g_concat
         assign addr_o = {y, x};
      end else begin : g_mult
         assign addr_o = AW'(y) * AW'(COLS) + AW'(x);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we) mem[addr_o] <= wdata;
   end

   assign rdata_o = mem[addr_o];
endmodule

// File: rtl/gram_window_addr.sv
module gram_window_addr
   import gwa_pkg::*;
#(
   parameter int COLS = 16,
   parameter int ROWS = 40,
   parameter int DW   = 8,
   parameter int CW   = 8,
   parameter int AW   = $clog2(COLS * ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          box_we,
   input  logic [CW-1:0] box_xs,
   input  logic [CW-1:0] box_ys,
   input  logic [CW-1:0] box_xe,
   input  logic [CW-1:0] box_ye,
   input  logic          dir_we,
   input  logic [7:0]    dir_code,
   input  logic          wr_valid,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_req,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] ram_addr,
   output logic          ram_we,
   output logic [DW-1:0] ram_rdata
);
   localparam int XW = (COLS > 1) ? $clog2(COLS) : 1;
   localparam int YW = (ROWS > 1) ? $clog2(ROWS) : 1;

   generate
      if (COLS < 2 || ROWS < 2) begin : g_bad_dims
         $error("gram_window_addr: COLS and ROWS must be at least 2");
      end
      if (CW < XW || CW < YW) begin : g_bad_cw
         $error("gram_window_addr: CW narrower than an axis");
      end
      if (AW < $clog2(COLS * ROWS)) begin : g_bad_aw
         $error("gram_window_addr: AW too small for memory");
      end
   endgenerate

   logic [XW-1:0] xs_n, xe_n, cur_x;
   logic [YW-1:0] ys_n, ye_n, cur_y;
   walk_mode_t    mode_n;
   logic          blocked, do_wr, do_rd, primed;
   logic [DW-1:0] hold_q;

   assign blocked = soft_rst | box_we | dir_we;
   assign do_wr   = wr_valid & ~blocked;
   assign do_rd   = rd_req & ~wr_valid & ~blocked;
   assign ram_we  = do_wr;

   gwa_box_regs #(.COLS(COLS), .ROWS(ROWS), .CW(CW), .XW(XW), .YW(YW)) u_box (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .box_we(box_we), .xs_i(box_xs), .ys_i(box_ys), .xe_i(box_xe), .ye_i(box_ye),
      .dir_we(dir_we), .dir_i(dir_code),
      .xs_n(xs_n), .xe_n(xe_n), .ys_n(ys_n), .ye_n(ye_n), .mode_n(mode_n)
   );

   gwa_walker #(.XW(XW), .YW(YW)) u_walk (
      .clk(clk), .rst_n(rst_n), .load(blocked), .step(do_wr | do_rd),
      .xs(xs_n), .xe(xe_n), .ys(ys_n), .ye(ye_n), .mode(mode_n),
      .x_o(cur_x), .y_o(cur_y)
   );

   gwa_ram #(.COLS(COLS), .ROWS(ROWS), .DW(DW), .XW(XW), .YW(YW), .AW(AW)) u_ram (
      .clk(clk), .we(do_wr), .x(cur_x), .y(cur_y), .wdata(wr_data),
      .addr_o(ram_addr), .rdata_o(ram_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed   <= 1'b0;
         hold_q   <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= do_rd & primed;
         if (blocked || do_wr) begin
            primed <= 1'b0;
         end else if (do_rd) begin
            primed <= 1'b1;
            hold_q <= ram_rdata;
            if (primed) rd_data <= hold_q;
         end
      end
   end
endmodule

// File: rtl/gwa_chk.sv
module gwa_chk #(
   parameter int COLS = 16,
   parameter int ROWS = 40,
   parameter int AW   = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          soft_rst,
   input logic          box_we,
   input logic          dir_we,
   input logic          wr_valid,
   input logic          rd_req,
   input logic          rd_valid,
   input logic [AW-1:0] ram_addr,
   input logic          ram_we
);
   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ram_addr == '0 && !rd_valid));

   // R2
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (ram_addr < AW'(COLS * ROWS)));

   // R7
   load_drops_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (box_we || dir_we) |=> !rd_valid);

   // R9
   valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_req));

   // R10
   soft_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ram_addr == '0));

   // R11
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && rd_req) |=> !rd_valid);
endmodule

bind gram_window_addr gwa_chk #(.COLS(COLS), .ROWS(ROWS), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .box_we(box_we), .dir_we(dir_we),
   .wr_valid(wr_valid), .rd_req(rd_req), .rd_valid(rd_valid),
   .ram_addr(ram_addr), .ram_we(ram_we)
);

// File: tb/sim_gram_window_addr.sv
module sim_gram_window_addr;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       box_we = 1'b0;
   logic [7:0] box_xs = '0, box_ys = '0, box_xe = '0, box_ye = '0;
   logic       dir_we = 1'b0;
   logic [7:0] dir_code = '0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_req = 1'b0;
   logic       rd_valid;
   logic [7:0] rd_data;
   logic [9:0] ram_addr;
   logic       ram_we;
   logic [7:0] ram_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [7:0] shadow [640];
   int ord[$];

   always #4 clk = ~clk;

   gram_window_addr u0 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .box_we(box_we), .box_xs(box_xs), .box_ys(box_ys), .box_xe(box_xe), .box_ye(box_ye),
      .dir_we(dir_we), .dir_code(dir_code),
      .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .ram_addr(ram_addr), .ram_we(ram_we), .ram_rdata(ram_rdata)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected walk order for an already clamped box
   task automatic build_order(input int xs, input int ys, input int xe, input int ye,
                              input logic [7:0] mode);
      int nx = xe - xs + 1;
      int ny = ye - ys + 1;
      ord.delete();
      if (!mode[3]) begin
         for (int j = 0; j < ny; j++)
            for (int i = 0; i < nx; i++)
               ord.push_back((mode[1] ? ye - j : ys + j) * 16 + (mode[0] ? xe - i : xs + i));
      end else begin
         for (int i = 0; i < nx; i++)
            for (int j = 0; j < ny; j++)
               ord.push_back((mode[1] ? ye - j : ys + j) * 16 + (mode[0] ? xe - i : xs + i));
      end
   endtask

   task automatic load_box(input int xs, input int ys, input int xe, input int ye,
                           input logic [7:0] mode);
      box_we = 1'b1; dir_we = 1'b1;
      box_xs = 8'(xs); box_ys = 8'(ys); box_xe = 8'(xe); box_ye = 8'(ye);
      dir_code = mode;
      @(negedge clk);
      box_we = 1'b0; dir_we = 1'b0;
   endtask

   task automatic write_byte(input logic [7:0] d, input int exp_addr, input string req);
      wr_valid = 1'b1; wr_data = d;
      #1;
      chk(ram_we === 1'b1, "R2 ram_we", int'(ram_we), 1);
      chk(ram_addr == 10'(exp_addr), req, int'(ram_addr), exp_addr);
      shadow[exp_addr] = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic read_byte(output logic v, output logic [7:0] d);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      v = rd_valid;
      d = rd_data;
   endtask

   task automatic t_reset;
      chk(ram_addr == 0, "R1 addr", int'(ram_addr), 0);
      chk(ram_we == 0, "R1 we", int'(ram_we), 0);
      chk(rd_valid == 0, "R1 rd_valid", int'(rd_valid), 0);
   endtask

   // full-memory fill with default box, including wrap (R3, R4)
   task automatic t_fill_default;
      build_order(0, 0, 15, 39, 8'h00);
      for (int i = 0; i <= ord.size(); i++)
         write_byte(8'((i * 29 + 5) & 255), ord[i % ord.size()],
                    (i == ord.size()) ? "R4 full wrap" : "R3 default order");
      chk(ram_addr == 10'(ord[1]), "R4 after wrap", int'(ram_addr), ord[1]);
   endtask

   task automatic t_walk(input int xs, input int ys, input int xe, input int ye,
                         input logic [7:0] mode, input int seed, input string req);
      build_order(xs, ys, xe, ye, mode);
      load_box(xs, ys, xe, ye, mode);
      chk(ram_addr == 10'(ord[0]), "R7 start corner", int'(ram_addr), ord[0]);
      for (int i = 0; i <= ord.size(); i++)
         write_byte(8'((seed + i * 13) & 255), ord[i % ord.size()],
                    (i == ord.size()) ? "R4 box wrap" : req);
   endtask

   task automatic t_clamp;
      build_order(14, 37, 15, 39, 8'h00);
      load_box(14, 37, 8'h80, 8'hFF, 8'h00);
      for (int i = 0; i < ord.size(); i++)
         write_byte(8'(i + 100), ord[i], "R8 clamp");
      chk(ram_addr == 10'(ord[0]), "R8 clamp wrap", int'(ram_addr), ord[0]);
      load_box(9, 20, 3, 10, 8'h00);
      for (int i = 0; i < 3; i++)
         write_byte(8'(i + 7), 329, "R8 end below start");
   endtask

   task automatic t_blocked;
      logic v; logic [7:0] d;
      build_order(4, 10, 6, 11, 8'h00);
      box_we = 1'b1; dir_we = 1'b1;
      box_xs = 8'd4; box_ys = 8'd10; box_xe = 8'd6; box_ye = 8'd11; dir_code = 8'h00;
      wr_valid = 1'b1; wr_data = 8'hA5; rd_req = 1'b1;
      #1;
      chk(ram_we == 0, "R7 write ignored on load", int'(ram_we), 0);
      @(negedge clk);
      box_we = 1'b0; dir_we = 1'b0; wr_valid = 1'b0; rd_req = 1'b0;
      chk(rd_valid == 0, "R7 read ignored on load", int'(rd_valid), 0);
      chk(ram_addr == 10'(ord[0]), "R7 corner after load", int'(ram_addr), ord[0]);
      read_byte(v, d);
      read_byte(v, d);
      chk(v == 1, "R7 readback valid", int'(v), 1);
      chk(d == shadow[ord[0]], "R7 memory untouched", int'(d), int'(shadow[ord[0]]));
   endtask

   task automatic t_read(input int xs, input int ys, input int xe, input int ye,
                         input logic [7:0] mode);
      logic v; logic [7:0] d;
      build_order(xs, ys, xe, ye, mode);
      load_box(xs, ys, xe, ye, mode);
      read_byte(v, d);
      chk(v == 0, "R9 dummy read", int'(v), 0);
      for (int k = 0; k <= ord.size(); k++) begin
         read_byte(v, d);
         chk(v == 1, "R9 read valid", int'(v), 1);
         chk(d == shadow[ord[k % ord.size()]], "R9 read data", int'(d),
             int'(shadow[ord[k % ord.size()]]));
      end
   endtask

   task automatic t_wr_rd;
      logic v; logic [7:0] d;
      build_order(2, 3, 5, 6, 8'h00);
      load_box(2, 3, 5, 6, 8'h00);
      wr_valid = 1'b1; rd_req = 1'b1; wr_data = 8'h3C;
      shadow[ord[0]] = 8'h3C;
      @(negedge clk);
      wr_valid = 1'b0; rd_req = 1'b0;
      chk(rd_valid == 0, "R11 no read data", int'(rd_valid), 0);
      chk(ram_addr == 10'(ord[1]), "R11 one step", int'(ram_addr), ord[1]);
      load_box(2, 3, 5, 6, 8'h00);
      read_byte(v, d);
      chk(v == 0, "R9 dummy after write", int'(v), 0);
      read_byte(v, d);
      chk(d == 8'h3C, "R11 write landed", int'(d), 'h3C);
   endtask

   task automatic t_soft;
      t_walk(1, 1, 3, 2, 8'h03, 200, "R5 both down");
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      chk(ram_addr == 0, "R10 origin", int'(ram_addr), 0);
      t_read(0, 0, 15, 39, 8'h00);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      write_byte(8'h11, 0, "R10 default box");
      write_byte(8'h12, 1, "R10 default mode");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill_default();
      t_walk(2, 3, 5, 6, 8'h00, 1, "R3 box order");
      t_walk(2, 3, 5, 6, 8'h01, 2, "R5 x down");
      t_walk(2, 3, 5, 6, 8'h02, 3, "R5 y down");
      t_walk(2, 3, 5, 6, 8'h08, 4, "R6 column first");
      t_walk(7, 30, 9, 33, 8'h0B, 5, "R6 column first down");
      t_walk(7, 30, 9, 33, 8'hF4, 6, "R6 ignored bits");
      t_clamp();
      t_blocked();
      t_read(7, 30, 9, 33, 8'h09);
      t_wr_rd();
      t_soft();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      done = 1;
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule